// File: doc/BRIEF.md
# Completer Request Descriptor Parser

This block sits on the inbound request stream of a PCIe endpoint. Every request reaches it as one stream packet that opens with a fixed 16-byte descriptor, and payload beats may follow. The block collects the descriptor, which takes two beats on a 64-bit data path and one beat on a 128-bit path. It then decodes the descriptor into separate fields and presents them together with a one-cycle strobe.

Alongside the fields it classifies the request and flags whether the request is non-posted. It also raises flags for a zero-length memory access, an I/O request whose dword count is not 1, and a dword count above the legal maximum. The returned address is trimmed to the aperture of the matching BAR. Every accepted beat, whether descriptor or payload, is forwarded through one output register stage. A marker on the output tells payload beats apart from descriptor beats, so downstream logic can pick up the data after the fields arrive.

Top module: `cq_desc_parser`

## Requirements
- R1: Each beat accepted on the input appears on `m_data`/`m_last` one cycle later with `m_valid` high. `m_payload` is 0 for descriptor beats and 1 for every later beat of the packet.
- R2: With `DATA_W`=64 the descriptor is beat 0 (bits 63:0) plus beat 1 (bits 127:64). With `DATA_W`=128 it is beat 0 alone. `d_valid` is high for exactly one cycle, in the cycle after the last descriptor beat is accepted, and the `d_*` fields hold their values until the next strobe.
- R3: The fields are taken from these descriptor bit positions: address type 1:0, dword count 74:64, request type 78:75, requester ID 95:80, tag 103:96, target function 111:104, BAR ID 114:112, BAR aperture 120:115, traffic class 123:121. Attribute bit 124 gives `d_no_snoop`, bit 125 gives `d_relaxed` and bit 126 gives `d_id_order`. Bit 127 is ignored.
- R4: `d_addr` carries descriptor bits 63:2 in the same positions, with bits 1:0 at zero. Every bit at or above the BAR aperture value N is also zero, so aperture 0 gives an all-zero address.
- R5: `d_req_class` encodes the request type as follows: 0 memory read (0000), 1 memory write (0001), 2 I/O (0010, 0011), 3 atomic (0100, 0101, 0110), 4 locked read (0111), 5 message (1100, 1101, 1110), 6 anything else (1000 to 1011, 1111).
- R6: `d_non_posted` is 1 exactly for request types 0000, 0010, 0011, 0100, 0101, 0110 and 0111.
- R7: `d_zero_len` is 1 exactly when the type is memory read or memory write, the dword count is 1, and the first-byte enables captured with beat 0 are all zero.
- R8: `d_io_len_err` is 1 exactly when the type is I/O read or I/O write and the dword count is not 1.
- R9: `d_len_err` is 1 exactly when the dword count exceeds 256.
- R10: `s_ready` is low while `m_valid` is high and `m_ready` is low. Such a stall holds `m_data`, `m_last` and `m_valid`. A descriptor beat that is waiting is not captured and produces no strobe until it is accepted.
- R11: Beat counting restarts only after a beat with `s_last`. Payload beats never produce a strobe. A packet that ends before its descriptor is complete produces no strobe, and the following packet decodes normally.
- R12: During and straight after reset, `s_ready` is 1, `m_valid` is 0, `d_valid` is 0 and the fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | DATA_W | Input stream data |
| s_first_be | input | 4 | First dword byte enables, valid with beat 0 |
| s_valid | input | 1 | Input beat valid |
| s_last | input | 1 | Final beat of the packet |
| s_ready | output | 1 | Input beat can be accepted |
| m_data | output | DATA_W | Forwarded beat data |
| m_valid | output | 1 | Forwarded beat valid |
| m_last | output | 1 | Forwarded final beat |
| m_payload | output | 1 | Forwarded beat is payload, not descriptor |
| m_ready | input | 1 | Downstream accepts forwarded beat |
| d_valid | output | 1 | One-cycle strobe: decoded fields updated |
| d_addr_type | output | 2 | Address type |
| d_addr | output | 64 | Aperture-trimmed byte address of first dword |
| d_dw_count | output | 11 | Dword count |
| d_req_type | output | 4 | Raw request type |
| d_req_class | output | 3 | Request class code (R5) |
| d_requester_id | output | 16 | Requester ID |
| d_tag | output | 8 | Tag |
| d_target_fn | output | 8 | Target function |
| d_bar_id | output | 3 | Matching BAR number |
| d_bar_aperture | output | 6 | BAR aperture in address bits |
| d_tc | output | 3 | Traffic class |
| d_no_snoop | output | 1 | No Snoop attribute |
| d_relaxed | output | 1 | Relaxed Ordering attribute |
| d_id_order | output | 1 | ID-Based Ordering attribute |
| d_non_posted | output | 1 | Request expects a completion |
| d_zero_len | output | 1 | Zero-length memory access |
| d_io_len_err | output | 1 | I/O request with dword count other than 1 |
| d_len_err | output | 1 | Dword count above 256 |

## Verification
The hardest state to reach is a stall that falls between the two halves of a 64-bit descriptor. Beat 0 sits in the output register and the high half waits on the input. Only the timing of `m_ready` against the second beat reaches this state. The stimulus drops `m_ready` just before beat 0 is sent, then holds the second beat pending for several cycles. During that wait the bench confirms that no strobe appears and that the forwarded data is frozen. It then releases `m_ready` and checks that the decoded fields come from the delayed half. A one-beat packet that ends early is also sent, to show that an incomplete descriptor leaves nothing behind.

// File: rtl/cq_desc_pkg.sv
package cq_desc_pkg;

    localparam logic [3:0] RT_MEM_RD  = 4'b0000;
    localparam logic [3:0] RT_MEM_WR  = 4'b0001;
    localparam logic [3:0] RT_IO_RD   = 4'b0010;
    localparam logic [3:0] RT_IO_WR   = 4'b0011;
    localparam logic [3:0] RT_FADD    = 4'b0100;
    localparam logic [3:0] RT_SWAP    = 4'b0101;
    localparam logic [3:0] RT_CAS     = 4'b0110;
    localparam logic [3:0] RT_LOCK_RD = 4'b0111;
    localparam logic [3:0] RT_MSG     = 4'b1100;
    localparam logic [3:0] RT_MSG_VD  = 4'b1101;
    localparam logic [3:0] RT_MSG_ATS = 4'b1110;

    localparam int DESC_BITS = 127;
    localparam logic [10:0] MAX_DW = 11'd256;

    typedef enum logic [2:0] {
        CLS_MEM_RD = 3'd0,
        CLS_MEM_WR = 3'd1,
        CLS_IO     = 3'd2,
        CLS_ATOMIC = 3'd3,
        CLS_LOCKED = 3'd4,
        CLS_MSG    = 3'd5,
        CLS_OTHER  = 3'd6
    } req_class_e;

    typedef struct packed {
        logic [1:0]  addr_type;
        logic [63:0] addr;
        logic [10:0] dw_count;
        logic [3:0]  req_type;
        req_class_e  req_class;
        logic [15:0] rid;
        logic [7:0]  tag;
        logic [7:0]  target_fn;
        logic [2:0]  bar_id;
        logic [5:0]  aperture;
        logic [2:0]  tc;
        logic        no_snoop;
        logic        relaxed;
        logic        id_order;
        logic        non_posted;
        logic        zero_len;
        logic        io_len_err;
        logic        len_err;
    } cq_fields_t;

endpackage

// File: rtl/cq_beat_tracker.sv
module cq_beat_tracker #(
    parameter int DESC_BEATS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_acc,
    input  logic beat_last,
    output logic first_beat,
    output logic desc_end,
    output logic in_payload
);
    localparam int IDX_W = 2;
    localparam logic [IDX_W-1:0] LAST_DESC = IDX_W'(DESC_BEATS - 1);
    localparam logic [IDX_W-1:0] IDX_MAX   = {IDX_W{1'b1}};

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (beat_acc) begin
            if (beat_last) begin
                idx_d = '0;
            end else if (idx_q != IDX_MAX) begin
                idx_d = idx_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

    assign first_beat = (idx_q == '0);
    assign desc_end   = (idx_q == LAST_DESC);
    assign in_payload = (idx_q > LAST_DESC);

endmodule

// File: rtl/cq_field_decode.sv
module cq_field_decode
    import cq_desc_pkg::*;
(
    input  logic [DESC_BITS-1:0] desc,
    input  logic [3:0]           first_be,
    output cq_fields_t           fld
);
    logic [3:0]  rt;
    logic [10:0] dw;
    logic [5:0]  ap;
    logic [63:0] keep_mask;

    always_comb begin
        rt        = desc[78:75];
        dw        = desc[74:64];
        ap        = desc[120:115];
        keep_mask = ~({64{1'b1}} << ap);

        fld.addr_type = desc[1:0];
        fld.addr      = {desc[63:2], 2'b00} & keep_mask;
        fld.dw_count  = dw;
        fld.req_type  = rt;
        fld.rid       = desc[95:80];
        fld.tag       = desc[103:96];
        fld.target_fn = desc[111:104];
        fld.bar_id    = desc[114:112];
        fld.aperture  = ap;
        fld.tc        = desc[123:121];
        fld.no_snoop  = desc[124];
        fld.relaxed   = desc[125];
        fld.id_order  = desc[126];

        unique case (rt)
            RT_MEM_RD:                     fld.req_class = CLS_MEM_RD;
            RT_MEM_WR:                     fld.req_class = CLS_MEM_WR;
            RT_IO_RD, RT_IO_WR:            fld.req_class = CLS_IO;
            RT_FADD, RT_SWAP, RT_CAS:      fld.req_class = CLS_ATOMIC;
            RT_LOCK_RD:                    fld.req_class = CLS_LOCKED;
            RT_MSG, RT_MSG_VD, RT_MSG_ATS: fld.req_class = CLS_MSG;
            default:                       fld.req_class = CLS_OTHER;
        endcase

        fld.non_posted = (rt == RT_MEM_RD) || (rt == RT_IO_RD) || (rt == RT_IO_WR)
                      || (rt == RT_FADD) || (rt == RT_SWAP) || (rt == RT_CAS)
                      || (rt == RT_LOCK_RD);
        fld.zero_len   = ((rt == RT_MEM_RD) || (rt == RT_MEM_WR))
                      && (dw == 11'd1) && (first_be == 4'b0000);
        fld.io_len_err = ((rt == RT_IO_RD) || (rt == RT_IO_WR)) && (dw != 11'd1);
        fld.len_err    = (dw > MAX_DW);
    end

endmodule

// File: rtl/cq_desc_parser.sv
module cq_desc_parser
    import cq_desc_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] s_data,
    input  logic [3:0]        s_first_be,
    input  logic              s_valid,
    input  logic              s_last,
    output logic              s_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_valid,
    output logic              m_last,
    output logic              m_payload,
    input  logic              m_ready,
    output logic              d_valid,
    output logic [1:0]        d_addr_type,
    output logic [63:0]       d_addr,
    output logic [10:0]       d_dw_count,
    output logic [3:0]        d_req_type,
    output logic [2:0]        d_req_class,
    output logic [15:0]       d_requester_id,
    output logic [7:0]        d_tag,
    output logic [7:0]        d_target_fn,
    output logic [2:0]        d_bar_id,
    output logic [5:0]        d_bar_aperture,
    output logic [2:0]        d_tc,
    output logic              d_no_snoop,
    output logic              d_relaxed,
    output logic              d_id_order,
    output logic              d_non_posted,
    output logic              d_zero_len,
    output logic              d_io_len_err,
    output logic              d_len_err
);
    localparam int DESC_BEATS = (DATA_W == 64) ? 2 : 1;
    localparam int HALF_W     = 64;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              last;
        logic              payload;
        logic              dval;
        cq_fields_t        f;
    } st_t;

    st_t st_d, st_q;

    logic                 acc;
    logic                 first_beat;
    logic                 desc_end;
    logic                 in_payload;
    logic [DESC_BITS-1:0] desc_full;
    logic [3:0]           desc_be;
    cq_fields_t           dec;

    assign s_ready = !st_q.valid || m_ready;
    assign acc     = s_valid && s_ready;

    cq_beat_tracker #(
        .DESC_BEATS(DESC_BEATS)
    ) trk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_acc  (acc),
        .beat_last (s_last),
        .first_beat(first_beat),
        .desc_end  (desc_end),
        .in_payload(in_payload)
    );

    generate
        if (DESC_BEATS == 2) begin : g_two_beat
            logic [HALF_W-1:0] lo_d, lo_q;
            logic [3:0]        be_d, be_q;

            always_comb begin
                lo_d = lo_q;
                be_d = be_q;
                if (acc && first_beat) begin
                    lo_d = s_data[HALF_W-1:0];
                    be_d = s_first_be;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lo_q <= '0;
                    be_q <= '0;
                end else begin
                    lo_q <= lo_d;
                    be_q <= be_d;
                end
            end

            assign desc_full = {s_data[DESC_BITS-HALF_W-1:0], lo_q};
            assign desc_be   = be_q;
        end else begin : g_one_beat
            assign desc_full = s_data[DESC_BITS-1:0];
            assign desc_be   = s_first_be;
        end
    endgenerate

    cq_field_decode dec_i (
        .desc    (desc_full),
        .first_be(desc_be),
        .fld     (dec)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = st_q.valid && !m_ready;
        st_d.dval  = 1'b0;
        if (acc) begin
            st_d.valid   = 1'b1;
            st_d.data    = s_data;
            st_d.last    = s_last;
            st_d.payload = in_payload;
            if (desc_end) begin
                st_d.dval = 1'b1;
                st_d.f    = dec;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign m_data         = st_q.data;
    assign m_valid        = st_q.valid;
    assign m_last         = st_q.last;
    assign m_payload      = st_q.payload;
    assign d_valid        = st_q.dval;
    assign d_addr_type    = st_q.f.addr_type;
    assign d_addr         = st_q.f.addr;
    assign d_dw_count     = st_q.f.dw_count;
    assign d_req_type     = st_q.f.req_type;
    assign d_req_class    = st_q.f.req_class;
    assign d_requester_id = st_q.f.rid;
    assign d_tag          = st_q.f.tag;
    assign d_target_fn    = st_q.f.target_fn;
    assign d_bar_id       = st_q.f.bar_id;
    assign d_bar_aperture = st_q.f.aperture;
    assign d_tc           = st_q.f.tc;
    assign d_no_snoop     = st_q.f.no_snoop;
    assign d_relaxed      = st_q.f.relaxed;
    assign d_id_order     = st_q.f.id_order;
    assign d_non_posted   = st_q.f.non_posted;
    assign d_zero_len     = st_q.f.zero_len;
    assign d_io_len_err   = st_q.f.io_len_err;
    assign d_len_err      = st_q.f.len_err;

endmodule

// File: rtl/cq_desc_parser_chk.sv
module cq_desc_parser_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_valid,
    input logic              s_ready,
    input logic [DATA_W-1:0] m_data,
    input logic              m_valid,
    input logic              m_last,
    input logic              m_ready,
    input logic              d_valid,
    input logic [63:0]       d_addr,
    input logic [5:0]        d_bar_aperture,
    input logic [2:0]        d_req_class,
    input logic [3:0]        d_req_type,
    input logic [10:0]       d_dw_count,
    input logic [7:0]        d_tag,
    input logic              d_non_posted,
    input logic              d_zero_len,
    input logic              d_io_len_err
);
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

    p_strobe_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid |-> $past(s_valid && s_ready));

    p_fields_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !d_valid |-> ($stable(d_addr) && $stable(d_tag) && $stable(d_req_type)));

    p_addr_trim_r4: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid |-> ((d_addr >> d_bar_aperture) == 64'd0));

    p_msg_posted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && d_req_class == 3'd5) |-> !d_non_posted);

    p_zero_len_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && d_zero_len) |-> (d_dw_count == 11'd1 && d_req_class <= 3'd1));

    p_io_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && d_req_class == 3'd2 && d_dw_count != 11'd1) |-> d_io_len_err);

    generate
        if (DATA_W == 64) begin : g_two_beat_chk
            p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
                d_valid |=> !d_valid);
        end
    endgenerate

endmodule

bind cq_desc_parser cq_desc_parser_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/cq_desc_parser_tb_top.sv
`timescale 1ns/1ps
module cq_desc_parser_tb_top;

    localparam int DATA_W = 64;
    localparam int NV = 18;

    typedef struct packed {
        logic [3:0]  rt;
        logic [10:0] dw;
        logic [3:0]  fbe;
        logic [5:0]  ap;
        logic [63:0] addr;
        logic [2:0]  npay;
        logic [2:0]  cls;
        logic        np;
        logic        zl;
        logic        ioe;
        logic        le;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{4'h0, 11'd4,   4'hF, 6'd12, 64'h0000_1234_5678_9ABF, 3'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'h1, 11'd2,   4'hF, 6'd20, 64'hFFFF_FFFF_FFFF_FFFE, 3'd1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'h0, 11'd1,   4'h0, 6'd63, 64'h8000_0000_0000_0040, 3'd0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{4'h1, 11'd1,   4'h0, 6'd32, 64'h0000_0001_0000_1000, 3'd1, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{4'h2, 11'd1,   4'h0, 6'd8,  64'h0000_0000_0000_0CF4, 3'd0, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'h3, 11'd2,   4'hF, 6'd8,  64'h0000_0000_0000_0010, 3'd1, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0},
        '{4'h4, 11'd1,   4'hF, 6'd16, 64'hABCD_0000_0001_2344, 3'd1, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'h5, 11'd2,   4'hF, 6'd16, 64'h0000_0000_0000_FFF8, 3'd1, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'h6, 11'd4,   4'hF, 6'd40, 64'h0000_00FF_FFFF_FFF8, 3'd2, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'h7, 11'd1,   4'hF, 6'd12, 64'h0000_0000_0000_2000, 3'd0, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'hC, 11'd0,   4'h0, 6'd0,  64'h0000_0000_0000_0000, 3'd0, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'hD, 11'd2,   4'hF, 6'd0,  64'h0000_0000_0000_0000, 3'd1, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'hE, 11'd0,   4'h0, 6'd0,  64'h0000_0000_0000_0000, 3'd0, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'h8, 11'd1,   4'hF, 6'd0,  64'h0000_0000_0000_0000, 3'd0, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'hF, 11'd1,   4'hF, 6'd0,  64'h0000_0000_0000_0000, 3'd0, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'h1, 11'd257, 4'hF, 6'd30, 64'h0000_0000_3FFF_FFFC, 3'd3, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1},
        '{4'h0, 11'd256, 4'hF, 6'd0,  64'hFFFF_0000_FFFF_0004, 3'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'h0, 11'd1,   4'h1, 6'd12, 64'h0000_0000_0000_0FFC, 3'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] s_data = '0;
    logic [3:0]        s_first_be = '0;
    logic              s_valid = 1'b0;
    logic              s_last = 1'b0;
    logic              s_ready;
    logic [DATA_W-1:0] m_data;
    logic              m_valid, m_last, m_payload;
    logic              m_ready = 1'b1;
    logic              d_valid;
    logic [1:0]        d_addr_type;
    logic [63:0]       d_addr;
    logic [10:0]       d_dw_count;
    logic [3:0]        d_req_type;
    logic [2:0]        d_req_class;
    logic [15:0]       d_requester_id;
    logic [7:0]        d_tag, d_target_fn;
    logic [2:0]        d_bar_id, d_tc;
    logic [5:0]        d_bar_aperture;
    logic              d_no_snoop, d_relaxed, d_id_order;
    logic              d_non_posted, d_zero_len, d_io_len_err, d_len_err;

    int total = 0;
    int fails = 0;
    int dv_cnt = 0;
    int dsc_cnt = 0;
    int pay_cnt = 0;
    int last_cnt = 0;
    logic [DATA_W-1:0] last_pay = '0;

    always #5 clk = ~clk;

    cq_desc_parser #(.DATA_W(DATA_W)) dut_i (.*);

    always @(negedge clk) begin
        if (rst_n) begin
            if (d_valid) dv_cnt++;
            if (m_valid && m_ready) begin
                if (m_payload) begin
                    pay_cnt++;
                    last_pay = m_data;
                end else begin
                    dsc_cnt++;
                end
                if (m_last) last_cnt++;
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    task automatic drive_beat(input logic [DATA_W-1:0] d, input logic [3:0] be, input logic lst);
        logic ok;
        @(negedge clk);
        s_valid = 1'b1; s_data = d; s_first_be = be; s_last = lst;
        forever begin
            #1 ok = s_ready;
            @(posedge clk);
            if (ok) break;
            @(negedge clk);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        #2;
    endtask

    function automatic logic [127:0] build_desc(input int i, input vec_t v);
        logic [127:0] d;
        d = '0;
        d[1:0]     = 2'(i % 4);
        d[63:2]    = v.addr[63:2];
        d[74:64]   = v.dw;
        d[78:75]   = v.rt;
        d[95:80]   = 16'hA000 + 16'(i);
        d[103:96]  = 8'h10 + 8'(i);
        d[111:104] = 8'(i * 3);
        d[114:112] = 3'(i % 8);
        d[120:115] = v.ap;
        d[123:121] = 3'((i + 1) % 8);
        d[126:124] = 3'((i + 2) % 8);
        d[127]     = 1'b1;
        return d;
    endfunction

    function automatic logic [63:0] trim_addr(input logic [63:0] a, input int ap);
        logic [63:0] r;
        r = '0;
        for (int b = 2; b < 64; b++) begin
            if (b < ap) r[b] = a[b];
        end
        return r;
    endfunction

    task automatic send_pkt(input logic [127:0] d, input logic [3:0] be, input int npay);
        drive_beat(d[63:0], be, 1'b0);
        drive_beat(d[127:64], 4'h0, (npay == 0));
        for (int k = 0; k < npay; k++) begin
            drive_beat({32'hDA7A_0000, 32'(k)}, 4'h0, (k == npay - 1));
        end
        go_idle();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R12 s_ready in reset", 64'(s_ready), 64'd1);
        check("R12 m_valid in reset", 64'(m_valid), 64'd0);
        check("R12 d_valid in reset", 64'(d_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R12 fields after reset", {d_addr[31:0], d_tag, d_dw_count, d_req_type, d_req_class, 2'b00}, 64'd0);
        check("R12 m_valid after reset", 64'(m_valid), 64'd0);

        for (int i = 0; i < NV; i++) begin
            automatic vec_t v = VECS[i];
            automatic logic [127:0] d = build_desc(i, v);
            automatic int dv0 = dv_cnt;
            automatic int ds0 = dsc_cnt;
            automatic int py0 = pay_cnt;
            automatic int ls0 = last_cnt;
            send_pkt(d, v.fbe, int'(v.npay));
            settle();
            check($sformatf("R2 strobe count v%0d", i), 64'(dv_cnt - dv0), 64'd1);
            check($sformatf("R1 desc beats v%0d", i), 64'(dsc_cnt - ds0), 64'd2);
            check($sformatf("R1 payload beats v%0d", i), 64'(pay_cnt - py0), 64'(v.npay));
            check($sformatf("R1 last beats v%0d", i), 64'(last_cnt - ls0), 64'd1);
            if (v.npay != 0)
                check($sformatf("R1 payload data v%0d", i), last_pay, {32'hDA7A_0000, 32'(v.npay - 1)});
            check($sformatf("R4 address v%0d", i), d_addr, trim_addr(v.addr, int'(v.ap)));
            check($sformatf("R3 type/count v%0d", i), {d_req_type, d_dw_count, d_addr_type},
                  64'({v.rt, v.dw, d[1:0]}));
            check($sformatf("R3 id/tag/fn v%0d", i), {d_requester_id, d_tag, d_target_fn},
                  64'({d[95:80], d[103:96], d[111:104]}));
            check($sformatf("R3 bar/ap/tc/attr v%0d", i),
                  {d_bar_id, d_bar_aperture, d_tc, d_id_order, d_relaxed, d_no_snoop},
                  64'({d[114:112], d[120:115], d[123:121], d[126:124]}));
            check($sformatf("R5 class v%0d", i), 64'(d_req_class), 64'(v.cls));
            check($sformatf("R6 non-posted v%0d", i), 64'(d_non_posted), 64'(v.np));
            check($sformatf("R7 zero length v%0d", i), 64'(d_zero_len), 64'(v.zl));
            check($sformatf("R8 io count error v%0d", i), 64'(d_io_len_err), 64'(v.ioe));
            check($sformatf("R9 length error v%0d", i), 64'(d_len_err), 64'(v.le));
        end

        begin : stall_mid_descriptor
            automatic vec_t v = VECS[6];
            automatic logic [127:0] d = build_desc(40, v);
            automatic int dv0;
            @(negedge clk);
            m_ready = 1'b0;
            dv0 = dv_cnt;
            drive_beat(d[63:0], 4'hF, 1'b0);
            @(negedge clk);
            s_valid = 1'b1; s_data = d[127:64]; s_last = 1'b1;
            #1;
            check("R10 s_ready low while stalled", 64'(s_ready), 64'd0);
            for (int c = 0; c < 3; c++) begin
                @(negedge clk);
                #1;
                check("R10 held data during stall", m_data, d[63:0]);
                check("R10 no strobe during stall", 64'(dv_cnt - dv0), 64'd0);
            end
            m_ready = 1'b1;
            @(posedge clk);
            go_idle();
            settle();
            check("R10 strobe after release", 64'(dv_cnt - dv0), 64'd1);
            check("R10 tag from delayed half", 64'(d_tag), 64'(d[103:96]));
            check("R10 type from delayed half", 64'(d_req_type), 64'(v.rt));
        end

        begin : short_packet
            automatic logic [127:0] d = build_desc(50, VECS[0]);
            automatic logic [127:0] d2 = build_desc(51, VECS[1]);
            automatic int dv0 = dv_cnt;
            drive_beat(d[63:0], 4'hF, 1'b1);
            go_idle();
            settle();
            check("R11 no strobe for truncated packet", 64'(dv_cnt - dv0), 64'd0);
            send_pkt(d2, 4'hF, 2);
            settle();
            check("R11 next packet single strobe", 64'(dv_cnt - dv0), 64'd1);
            check("R11 next packet tag", 64'(d_tag), 64'(d2[103:96]));
            check("R11 next packet class", 64'(d_req_class), 64'd1);
        end

        finish_run();
    end

endmodule